// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the control and status register of each channel of a small multi-channel DMA controller. The CPU reaches it over a plain register bus: an address, a write strobe, a read strobe, a byte of write data and a registered byte of read data. On the other side it talks to the per-channel transfer engine. It receives a terminal-count strobe and a hardware request line per channel, plus a shared non-maskable interrupt line. It returns a one-cycle accept pulse and a one-cycle abort pulse per channel.

Each channel register carries an enable bit, a multi-transfer bit, two command bits (software start and forced stop) and a sticky end-of-transfer flag. Reading a register clears that flag. The multi-transfer bit decides whether an end of transfer leaves the channel armed. While the flag is still set, an armed channel in multi-transfer mode keeps granting hardware requests, but it holds back software starts until the flag has been read.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every channel register reads 00h, and no accept or abort pulse is issued.
- R2: Channel c sits at byte offset 2*c. Bit 7 is the end-of-transfer flag, bit 3 is multi-transfer, bit 2 is forced stop, bit 1 is software start and bit 0 is enable. Bits 3 and 0 read back as last written. Bits 6 to 4, 2 and 1 always read 0. Read data appears on the cycle after the read strobe.
- R3: A terminal-count strobe sets the channel's flag. A CPU write cannot set or clear the flag. A read of that channel's register clears it.
- R4: When a terminal-count strobe and a read of the same register fall in the same cycle, the read returns the flag as 1 and the flag stays set.
- R5: On a terminal-count strobe, the enable bit is cleared if multi-transfer is 0 and kept if multi-transfer is 1.
- R6: A hardware request gives an accept pulse on the next cycle when enable is 1 and either the flag is 0 or multi-transfer is 1. In any other state the request is ignored.
- R7: A write with bit 1 set gives an accept pulse on the next cycle only if, before the write, enable was 1 and the flag was 0. Otherwise it has no effect.
- R8: A write with bit 2 set clears enable, even if the same write sets bit 0, and gives an abort pulse on that channel on the next cycle.
- R9: NMI clears enable on every channel, gives an abort pulse on every channel on the next cycle and blocks grants in that cycle. It leaves multi-transfer unchanged.
- R10: Writes to odd addresses change nothing. Reads from odd addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tc_evt | input | NUM_CH | Terminal-count strobe, one per channel |
| hw_req | input | NUM_CH | Hardware transfer request, one per channel |
| nmi | input | 1 | Non-maskable interrupt |
| ch_accept | output | NUM_CH | One-cycle pulse when a request is granted |
| ch_abort | output | NUM_CH | One-cycle forced-termination pulse |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. That holds for accept pulses, abort pulses and read data. A change of register state becomes visible through a read that starts one cycle later and returns its data one cycle after that. The bench therefore drives each step on a falling edge and samples all outputs on the next falling edge. It confirms state changes, such as a cleared flag or a dropped enable, with a following read step rather than within the same step.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_TC    = 7;
  localparam int BIT_MULTI = 3;
  localparam int BIT_STOP  = 2;
  localparam int BIT_START = 1;
  localparam int BIT_EN    = 0;
endpackage

// File: rtl/dmacc_decode.sv
module dmacc_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [NUM_CH-1:0] wr_sel,
  output logic [NUM_CH-1:0] rd_sel
);
  localparam int IDX_W = ADDR_W - 1;

  logic even;
  assign even = ~bus_addr[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    logic hit;
    assign hit       = even && (bus_addr[ADDR_W-1:1] == IDX_W'(c));
    assign wr_sel[c] = bus_wr && hit;
    assign rd_sel[c] = bus_rd && hit;
  end
endmodule

// File: rtl/dmacc_chan.sv
module dmacc_chan
  import dmacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic             rd_sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             tc_evt,
  input  logic             hw_req,
  input  logic             nmi,
  output logic [REG_W-1:0] reg_view,
  output logic             accept_o,
  output logic             abort_o
);
  logic en_q, multi_q, tc_q;
  logic stop_cmd, start_cmd, kill, sw_ok, hw_ok, en_d;
  logic unused_hi;

  assign unused_hi = ^wdata[REG_W-1:BIT_MULTI+1];

  always_comb begin
    stop_cmd  = wr_sel && wdata[BIT_STOP];
    start_cmd = wr_sel && wdata[BIT_START];
    kill      = nmi || stop_cmd;
    sw_ok     = start_cmd && en_q && !tc_q && !kill;
    hw_ok     = hw_req && en_q && (multi_q || !tc_q) && !kill;
    en_d      = en_q;
    if (wr_sel)              en_d = wdata[BIT_EN];
    if (tc_evt && !multi_q)  en_d = 1'b0;
    if (kill)                en_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      multi_q  <= 1'b0;
      tc_q     <= 1'b0;
      accept_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      en_q     <= en_d;
      if (wr_sel) multi_q <= wdata[BIT_MULTI];
      if (tc_evt)      tc_q <= 1'b1;
      else if (rd_sel) tc_q <= 1'b0;
      accept_o <= sw_ok || hw_ok;
      abort_o  <= kill;
    end
  end

  always_comb begin
    reg_view            = '0;
    reg_view[BIT_TC]    = tc_q || tc_evt;
    reg_view[BIT_MULTI] = multi_q;
    reg_view[BIT_EN]    = en_q;
  end

  assert_tc_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    tc_evt |=> tc_q);
  assert_single_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (tc_evt && !multi_q) |=> !en_q);
  assert_multi_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (tc_evt && multi_q && en_q && !nmi && !wr_sel) |=> en_q);
  assert_nmi_kill_R9: assert property (@(posedge clk) disable iff (rst)
    nmi |=> (!en_q && abort_o && !accept_o));
  assert_grant_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> $past(en_q));
  assert_sw_held_R7: assert property (@(posedge clk) disable iff (rst)
    (start_cmd && tc_q && !hw_req) |=> !accept_o);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dmacc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = $clog2(NUM_CH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] tc_evt,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              nmi,
  output logic [NUM_CH-1:0] ch_accept,
  output logic [NUM_CH-1:0] ch_abort
);
  logic [NUM_CH-1:0]            wr_sel, rd_sel;
  logic [NUM_CH-1:0][REG_W-1:0] views;
  logic [REG_W-1:0]             rd_mux;

  dmacc_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmacc_chan u_ch (
      .clk(clk), .rst(rst), .wr_sel(wr_sel[c]), .rd_sel(rd_sel[c]),
      .wdata(bus_wdata), .tc_evt(tc_evt[c]), .hw_req(hw_req[c]), .nmi(nmi),
      .reg_view(views[c]), .accept_o(ch_accept[c]), .abort_o(ch_abort[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (rd_sel[c]) rd_mux = rd_mux | views[c];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_read_pad_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_rdata[6:4] == 3'b000 && bus_rdata[2:1] == 2'b00));
  assert_odd_read_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[0]) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam time CLK_P = 10ns;
  localparam int  NV    = 36;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] addr;
    logic       wr;
    logic       rd;
    logic [7:0] wd;
    logic [3:0] tc;
    logic [3:0] hw;
    logic       nmi;
    logic [7:0] er;
    logic [3:0] ea;
    logic [3:0] eb;
  } vec_t;

  // req, addr, wr, rd, wdata, tc, hw, nmi, exp rdata, exp accept, exp abort
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'd0, 1'b1, 1'b0, 8'h09, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R2 arm ch0 multi
    '{4'd2,  3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h09, 4'h0, 4'h0}, // R2
    '{4'd2,  3'd2, 1'b1, 1'b0, 8'h01, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R2 arm ch1
    '{4'd2,  3'd2, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h01, 4'h0, 4'h0}, // R2
    '{4'd7,  3'd2, 1'b1, 1'b0, 8'h03, 4'h0, 4'h0, 1'b0, 8'h00, 4'h2, 4'h0}, // R7 start ok
    '{4'd6,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h1, 1'b0, 8'h00, 4'h1, 4'h0}, // R6 hw ok
    '{4'd6,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h4, 1'b0, 8'h00, 4'h0, 4'h0}, // R6 ch2 off
    '{4'd3,  3'd0, 1'b0, 1'b0, 8'h00, 4'h1, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R3 tc ch0
    '{4'd3,  3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h89, 4'h0, 4'h0}, // R3 R5 kept
    '{4'd3,  3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h09, 4'h0, 4'h0}, // R3 cleared
    '{4'd5,  3'd0, 1'b0, 1'b0, 8'h00, 4'h2, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R5 tc ch1
    '{4'd5,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 1'b0, 8'h00, 4'h0, 4'h0}, // R5 ch1 dropped
    '{4'd7,  3'd2, 1'b1, 1'b0, 8'h03, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R7 en was 0
    '{4'd7,  3'd2, 1'b1, 1'b0, 8'h03, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R7 flag set
    '{4'd6,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 1'b0, 8'h00, 4'h0, 4'h0}, // R6 flag, single
    '{4'd3,  3'd2, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h81, 4'h0, 4'h0}, // R3
    '{4'd6,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 1'b0, 8'h00, 4'h2, 4'h0}, // R6
    '{4'd5,  3'd0, 1'b0, 1'b0, 8'h00, 4'h1, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R5 tc ch0 multi
    '{4'd6,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h1, 1'b0, 8'h00, 4'h1, 4'h0}, // R6 multi, unread
    '{4'd7,  3'd0, 1'b1, 1'b0, 8'h0B, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R7 held
    '{4'd4,  3'd0, 1'b0, 1'b1, 8'h00, 4'h1, 4'h0, 1'b0, 8'h89, 4'h0, 4'h0}, // R4 collide
    '{4'd4,  3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h89, 4'h0, 4'h0}, // R4 kept
    '{4'd3,  3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h09, 4'h0, 4'h0}, // R3
    '{4'd7,  3'd0, 1'b1, 1'b0, 8'h0B, 4'h0, 4'h0, 1'b0, 8'h00, 4'h1, 4'h0}, // R7 now ok
    '{4'd8,  3'd0, 1'b1, 1'b0, 8'h05, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h1}, // R8 stop+en
    '{4'd8,  3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R8
    '{4'd3,  3'd4, 1'b1, 1'b0, 8'h81, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R3 write flag
    '{4'd3,  3'd4, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h01, 4'h0, 4'h0}, // R3
    '{4'd10, 3'd5, 1'b1, 1'b0, 8'h09, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R10 odd write
    '{4'd10, 3'd4, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h01, 4'h0, 4'h0}, // R10
    '{4'd10, 3'd5, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R10 odd read
    '{4'd9,  3'd6, 1'b1, 1'b0, 8'h09, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R9 arm ch3
    '{4'd9,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 8'h00, 4'h0, 4'hF}, // R9 nmi
    '{4'd9,  3'd4, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0}, // R9
    '{4'd9,  3'd6, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0, 8'h08, 4'h0, 4'h0}, // R9 multi kept
    '{4'd9,  3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 4'h0}  // R9 all off
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, nmi = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] tc_evt = '0, hw_req = '0;
  logic [3:0] ch_accept, ch_abort;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_evt(tc_evt), .hw_req(hw_req),
    .nmi(nmi), .ch_accept(ch_accept), .ch_abort(ch_abort)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d,
                       input logic [3:0] t, input logic [3:0] h, input logic n);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; tc_evt = t; hw_req = h; nmi = n;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; tc_evt = '0; hw_req = '0; nmi = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state on all registers and outputs
    check("R1 accept", {4'h0, ch_accept}, 8'h00);
    check("R1 abort",  {4'h0, ch_abort},  8'h00);
    for (int c = 0; c < 4; c++) begin
      drive(3'(2*c), 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0);
      check("R1 rdata", bus_rdata, 8'h00);
    end

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", VEC[i].req, i);
      drive(VEC[i].addr, VEC[i].wr, VEC[i].rd, VEC[i].wd, VEC[i].tc, VEC[i].hw, VEC[i].nmi);
      if (VEC[i].rd) check({tag, " rdata"}, bus_rdata, VEC[i].er);
      check({tag, " accept"}, {4'h0, ch_accept}, {4'h0, VEC[i].ea});
      check({tag, " abort"},  {4'h0, ch_abort},  {4'h0, VEC[i].eb});
    end

    // R1: reset in mid-run clears multi-transfer and flags
    drive(3'd6, 1'b1, 1'b0, 8'h09, 4'h8, 4'h0, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(3'd6, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0);
    check("R1 mid-run reset", bus_rdata, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule